// File: doc/BRIEF.md
# Interleaved Four-Phase Burst Clock Gate

This block derives four quarter-rate clock phases from a fast input clock and gates each of them with a regulation decision. The result is burst-mode pulse-frequency control for a time-interleaved switched-capacitor charge pump. A free-running two-bit slot counter splits the fast clock into four slots. Each phase lane owns a fixed slot offset, so the four phases rise one fast-clock period apart and each repeats every four fast cycles.

The regulation flag is high while the converter output sits below its reference. The flag passes through a two-flop synchronizer. Each lane then samples it on its own, a fixed number of fast cycles into its phase, and that sample decides whether the lane's two-cycle pulse is emitted. A sampled high emits the whole pulse. A sampled low suppresses the whole pulse. The capture element is cleared whenever the lane is outside its pulse window, so each decision is fresh. Each gated phase then drives a non-overlapping generator. The generator produces a complementary high-side and low-side pair, with a dead time counted in fast-clock cycles before either drive rises.

Top module: `burst_phase_gate`

## Requirements
- R1: While reset is low, every output is low. On the first fast-clock edge after reset is released, every output is also still low.
- R2: After reset release, number the fast-clock edges n = 1, 2, 3 and so on. Phase lane k (A=0, B=1, C=2, D=3) can only start a pulse after an edge with (n - k - SAMPLE_DLY) mod 4 = 0. As a result, enabled lanes rise in the order A, B, C, D, one fast cycle apart, and each lane repeats every four cycles.
- R3: The regulation input passes through two flops before use. The value that a lane samples at edge n is the input level present at edge n-2.
- R4: A lane's gated output after its start edge equals the synchronized flag sampled at that edge. When the flag is low at the start edge, no pulse is emitted for that phase.
- R5: A started pulse is exactly two fast cycles wide. A flag change during the pulse neither truncates it nor extends it.
- R6: A lane's high-side drive rises DEAD_CYC fast cycles after its gated phase rises. It falls on the same edge on which the gated phase falls.
- R7: A lane's low-side drive rises DEAD_CYC fast cycles after its gated phase falls. It is low whenever the gated phase is high.
- R8: A lane's high-side and low-side drives are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock (four times the phase rate) |
| rst_n | input | 1 | Active-low reset, synchronous to clk at release |
| below_ref | input | 1 | Asynchronous flag, high when the output is below the reference |
| phase_gated | output | 4 | Gated quarter-rate phases, bit 0 = A through bit 3 = D |
| drive_hi | output | 4 | High-side drive of each lane's non-overlapping pair |
| drive_lo | output | 4 | Low-side drive of each lane's non-overlapping pair |

## Verification
The assertions assume that the regulation flag is a level signal. Apart from the two synchronizer flops, they make no assumption about when it changes. Every property is therefore stated against the synchronized flag and the slot-open event inside the block, not against the raw pin. The relations between the gated phase and its drive pair assume the default dead time of one cycle, which fits inside the two-cycle pulse.

The stimulus changes the flag only at the falling edge of the fast clock. It holds the flag constant, toggles it every three cycles so that it crosses pulses in the middle, and drives it from a pseudo-random sequence. In every case the flag stays a clean single-bit level, as the synchronizer expects.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int unsigned NUM_PH = 4;
  localparam int unsigned PH_W   = $clog2(NUM_PH);

  typedef logic [PH_W-1:0] slot_t;

  // Offset of the current slot relative to a lane's own phase origin.
  function automatic slot_t slot_offset(slot_t cnt, int unsigned lane);
    return slot_t'(cnt - slot_t'(lane));
  endfunction

  // Slot index reached a given number of slots after a base slot.
  function automatic slot_t slot_add(int unsigned base, int unsigned steps);
    return slot_t'((base + steps) % NUM_PH);
  endfunction
endpackage

// File: rtl/bcg_sync.sv
module bcg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bcg_lane.sv
module bcg_lane
  import bcg_pkg::*;
#(
  parameter int unsigned LANE       = 0,
  parameter int unsigned SAMPLE_DLY = 1,
  parameter int unsigned DEAD_CYC   = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t cnt_nxt,
  input  logic  flag,
  output logic  slot_open,
  output logic  gated,
  output logic  hi,
  output logic  lo
);
  localparam slot_t OPEN_SLOT = slot_add(SAMPLE_DLY, 0);
  localparam slot_t HOLD_SLOT = slot_add(SAMPLE_DLY, 1);
  localparam int unsigned RUN_W = $clog2(DEAD_CYC + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEAD_CYC + 1);

  slot_t            off;
  logic             slot_hold;
  logic             gated_nxt;
  logic [RUN_W-1:0] hi_run, lo_run, hi_run_nxt, lo_run_nxt;

  always_comb begin
    off       = slot_offset(cnt_nxt, LANE);
    slot_open = (off == OPEN_SLOT);
    slot_hold = (off == HOLD_SLOT);
    // The gated register is the capture element: loaded at the open slot,
    // kept through the hold slot, cleared everywhere else.
    if (slot_open)      gated_nxt = flag;
    else if (slot_hold) gated_nxt = gated;
    else                gated_nxt = 1'b0;

    hi_run_nxt = '0;
    lo_run_nxt = '0;
    if (gated_nxt) hi_run_nxt = (hi_run == RUN_MAX) ? RUN_MAX : hi_run + 1'b1;
    else           lo_run_nxt = (lo_run == RUN_MAX) ? RUN_MAX : lo_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gated  <= 1'b0;
      hi_run <= '0;
      lo_run <= '0;
      hi     <= 1'b0;
      lo     <= 1'b0;
    end else begin
      gated  <= gated_nxt;
      hi_run <= hi_run_nxt;
      lo_run <= lo_run_nxt;
      hi     <= (hi_run_nxt == RUN_MAX);
      lo     <= (lo_run_nxt == RUN_MAX);
    end
  end
endmodule

// File: rtl/burst_phase_gate.sv
module burst_phase_gate
  import bcg_pkg::*;
#(
  parameter int unsigned SAMPLE_DLY  = 1,
  parameter int unsigned DEAD_CYC    = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              below_ref,
  output logic [NUM_PH-1:0] phase_gated,
  output logic [NUM_PH-1:0] drive_hi,
  output logic [NUM_PH-1:0] drive_lo
);
  slot_t             slot_cnt;
  slot_t             slot_cnt_nxt;
  logic              flag_s;
  logic [NUM_PH-1:0] lane_open;

  assign slot_cnt_nxt = slot_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_cnt <= '0;
    else        slot_cnt <= slot_cnt_nxt;
  end

  bcg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (below_ref),
    .q     (flag_s)
  );

  for (genvar k = 0; k < NUM_PH; k++) begin : g_lane
    bcg_lane #(
      .LANE       (k),
      .SAMPLE_DLY (SAMPLE_DLY),
      .DEAD_CYC   (DEAD_CYC)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_nxt   (slot_cnt_nxt),
      .flag      (flag_s),
      .slot_open (lane_open[k]),
      .gated     (phase_gated[k]),
      .hi        (drive_hi[k]),
      .lo        (drive_lo[k])
    );
  end
endmodule

// File: rtl/burst_phase_gate_chk.sv
module burst_phase_gate_chk #(
  parameter int unsigned NP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flag_s,
  input logic [NP-1:0] lane_open,
  input logic [NP-1:0] phase_gated,
  input logic [NP-1:0] drive_hi,
  input logic [NP-1:0] drive_lo
);
  // R2: at most one lane starts a pulse on any edge.
  a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_gated & ~$past(phase_gated)));

  for (genvar k = 0; k < NP; k++) begin : g_chk
    // R4: output after an open slot equals the synchronized flag at that slot.
    a_r4_open_decides: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lane_open[k]) |-> (phase_gated[k] == $past(flag_s)));
    // R4: a pulse can only begin right after an open slot.
    a_r4_rise_at_open: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_gated[k]) |-> $past(lane_open[k]));
    // R5: a started pulse is not truncated.
    a_r5_no_truncate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_gated[k]) |=> phase_gated[k]);
    // R5: a pulse is never longer than two cycles.
    a_r5_two_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_gated[k] && $past(phase_gated[k])) |=> !phase_gated[k]);
    // R6: high side rises only after the gated phase has been high a while.
    a_r6_hi_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_hi[k]) |-> (phase_gated[k] && $past(phase_gated[k])));
    // R6: high side drops with the gated phase.
    a_r6_hi_falls: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phase_gated[k]) |-> !drive_hi[k]);
    // R7: low side rises only after the gated phase has been low a while.
    a_r7_lo_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_lo[k]) |-> (!phase_gated[k] && !$past(phase_gated[k])));
    // R7: low side is off while the gated phase is on.
    a_r7_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
      phase_gated[k] |-> !drive_lo[k]);
    // R8: the complementary drives never overlap.
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(drive_hi[k] && drive_lo[k]));
  end
endmodule

bind burst_phase_gate burst_phase_gate_chk #(.NP(bcg_pkg::NUM_PH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flag_s      (flag_s),
  .lane_open   (lane_open),
  .phase_gated (phase_gated),
  .drive_hi    (drive_hi),
  .drive_lo    (drive_lo)
);

// File: tb/burst_phase_gate_bench.sv
module burst_phase_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DLY  = 1;
  localparam int DEAD = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       below_ref = 1'b0;
  logic [3:0] phase_gated, drive_hi, drive_lo;

  int checks = 0;
  int failures = 0;

  burst_phase_gate #(.SAMPLE_DLY(DLY), .DEAD_CYC(DEAD)) u_burst_phase_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .below_ref   (below_ref),
    .phase_gated (phase_gated),
    .drive_hi    (drive_hi),
    .drive_lo    (drive_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference timeline: edge count since reset and flag history per edge.
  int         n_edge = 0;
  logic       f0 = 0, f1 = 0, f2 = 0, f3 = 0;
  logic [3:0] exp_g = 0, prev_g = 0, exp_hi = 0, exp_lo = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      n_edge = 0; f0 = 0; f1 = 0; f2 = 0; f3 = 0;
      exp_g = 0; prev_g = 0; exp_hi = 0; exp_lo = 0;
    end else begin
      n_edge = n_edge + 1;
      f3 = f2; f2 = f1; f1 = f0; f0 = below_ref;
      prev_g = exp_g;
      for (int k = 0; k < 4; k++) begin
        // start edge: flag seen two edges earlier; second cycle: decision one edge older
        exp_g[k] = ((n_edge % 4) == ((k + DLY) % 4) && f2) ||
                   ((n_edge % 4) == ((k + DLY + 1) % 4) && f3);
      end
      exp_hi = exp_g & prev_g;
      exp_lo = (n_edge >= 2) ? (~exp_g & ~prev_g) : 4'b0000;
    end
  end

  task automatic check_outputs(input string tag);
    checks++;
    if (phase_gated !== exp_g) begin
      failures++;
      $display("FAIL %s/R2 phase_gated edge=%0d actual=%b expected=%b", tag, n_edge, phase_gated, exp_g);
    end
    checks++;
    if (drive_hi !== exp_hi) begin
      failures++;
      $display("FAIL %s/R6 drive_hi edge=%0d actual=%b expected=%b", tag, n_edge, drive_hi, exp_hi);
    end
    checks++;
    if (drive_lo !== exp_lo) begin
      failures++;
      $display("FAIL %s/R7 drive_lo edge=%0d actual=%b expected=%b", tag, n_edge, drive_lo, exp_lo);
    end
    checks++;
    if ((drive_hi & drive_lo) !== 4'b0000) begin
      failures++;
      $display("FAIL %s/R8 overlap actual=%b expected=0000", tag, drive_hi & drive_lo);
    end
  endtask

  // mode 0: flag held high, 1: held low, 2: toggles every 3 cycles, 3: pseudo-random
  task automatic run_pattern(input int cycles, input int mode, input string tag);
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_outputs(tag);
      case (mode)
        0: below_ref = 1'b1;
        1: below_ref = 1'b0;
        2: below_ref = ((i / 3) % 2) == 0;
        default: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          below_ref = lfsr[0];
        end
      endcase
    end
  endtask

  task automatic t_reset;
    below_ref = 1'b1;
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if ({phase_gated, drive_hi, drive_lo} !== 12'h000) begin
        failures++;
        $display("FAIL R1 in reset actual=%h expected=000", {phase_gated, drive_hi, drive_lo});
      end
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({phase_gated, drive_hi, drive_lo} !== 12'h000) begin
      failures++;
      $display("FAIL R1 first edge actual=%h expected=000", {phase_gated, drive_hi, drive_lo});
    end
  endtask

  // R3: raise the flag after a long low stretch and time the first pulse.
  task automatic t_sync_latency;
    int rise_at;
    int waited;
    below_ref = 1'b0;
    run_pattern(12, 1, "R3_quiet");
    @(negedge clk);
    below_ref = 1'b1;
    rise_at = n_edge + 1;
    waited = 0;
    while (phase_gated == 4'b0000 && waited < 8) begin
      @(negedge clk);
      waited++;
    end
    checks++;
    // first start edge m >= rise_at+2 for any lane; one lane opens each edge
    if (n_edge != rise_at + 2) begin
      failures++;
      $display("FAIL R3 first pulse edge actual=%0d expected=%0d", n_edge, rise_at + 2);
    end
  endtask

  // R4: with the flag low no lane emits anything for many periods.
  task automatic t_all_off;
    run_pattern(40, 1, "R4");
    checks++;
    if (phase_gated !== 4'b0000) begin
      failures++;
      $display("FAIL R4 idle gated actual=%b expected=0000", phase_gated);
    end
  endtask

  // R2: continuous enable, verify order A..D one cycle apart.
  task automatic t_order;
    int last_lane;
    int seen;
    run_pattern(12, 0, "R2");
    last_lane = -1;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_outputs("R2");
      for (int k = 0; k < 4; k++) begin
        if (exp_g[k] && !prev_g[k]) begin
          if (last_lane >= 0) begin
            checks++;
            if (k != (last_lane + 1) % 4) begin
              failures++;
              $display("FAIL R2 order actual=%0d expected=%0d", k, (last_lane + 1) % 4);
            end
          end
          last_lane = k;
          seen++;
        end
      end
    end
    checks++;
    if (seen != 8) begin
      failures++;
      $display("FAIL R2 rises in 8 cycles actual=%0d expected=8", seen);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_all_off();
    t_sync_latency();
    t_order();
    run_pattern(60, 2, "R5");
    run_pattern(200, 3, "R6_R7_R8");
    run_pattern(20, 1, "R4_tail");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule